// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block stores a stream of trace words into an on-chip RAM ring and tells host software where the valid data sits once capture ends. A write pointer walks the ring. It wraps to zero at the end of the RAM and leaves a sticky flag behind when it does. Each word read through the data register advances a separate read pointer, so software can drain the ring one word per access.

A trigger pulse arms a post-trigger countdown loaded from a programmable register. When the countdown is used up, storing stops and an acquisition-complete flag is raised. The amount of history kept ahead of the trigger therefore depends on the programmed count. The oldest valid word sits at index 0 when the ring has not wrapped. It sits at the write pointer when it has.

All host access goes through a register file of 32-bit registers selected by a 7-bit address. Read data is registered. Trace formatting and the debug transport that carries the register accesses are outside this block.

Top module: `trace_ring_buffer`

## Requirements
- R1: After reset the status word is 4'b1000: only the idle bit is set. Both pointers read as 0, and capture is disabled.
- R2: The registers at addresses 0, 1 and 2 always read back fixed values, and writes to them are ignored. Address 0 returns the identity constant 32'h7C0B_0001. Address 1 returns the RAM depth in words. Address 2 returns the trace word width in bits.
- R3: A word with `traceValid` high is stored at the write pointer only while capture is enabled and acquisition is not complete. Each stored word advances the write pointer by one, and the pointer wraps from DEPTH-1 to 0.
- R4: Status bit 0 (wrapped) is set when a store moves the write pointer from DEPTH-1 to 0. It stays set until capture is enabled again.
- R5: Status bit 1 (triggered) is set by the first `trigIn` pulse during active capture, and later pulses do nothing. After the trigger cycle exactly N further valid words are stored, where N is the trigger count register (address 7). Status bit 2 (complete) is then set, and nothing more is stored.
- R6: A read of address 4 returns the RAM word at the read pointer, zero-extended from bit 0. The read pointer then advances by one and wraps at DEPTH.
- R7: The read pointer (address 5), the write pointer (address 6) and the trigger count (address 7) can be written and read back. A pointer write takes the low pointer-width bits and takes priority over a pointer step in the same cycle.
- R8: The control register (address 8) holds capture enable in bit 0 and port demultiplex mode in bit 1, and both bits read back. A control write with bit 0 set clears status bits 0 to 2. A write of 0 stops capture and keeps those flags.
- R9: Status bit 3 (idle) is 1 whenever capture is disabled or acquisition is complete, and 0 otherwise.
- R10: Read data for an access with `regRdEn` high appears on `regRdData` in the following cycle, and holds until the next read.
- R11: Address 3 and the `statusWord` output report the four status bits in positions 0 to 3. The upper bits of address 3 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| traceValid | input | 1 | Trace word strobe |
| traceWord | input | WIDTH | Formatted trace word |
| trigIn | input | 1 | Trigger pulse |
| regSel | input | 7 | Register address |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Registered read data |
| statusWord | output | 4 | {idle, complete, triggered, wrapped} |

## Verification
The bench runs a behavioural model beside the design and compares the status word and read data on every clock. Stores are first attempted with capture disabled, which shows that the enable gates the RAM. A short capture is triggered early, and a later trigger pulse is sent to show it is ignored. A long capture with gaps in the valid strobe makes the ring wrap before the trigger. Draining it from the write pointer around the ring then shows that the oldest word and the read-pointer wrap are correct. A trigger count of zero and a stop through a control write of 0 cover the edges of the countdown and the sticky flags.

// File: rtl/trb_pkg.sv
package trb_pkg;
  localparam int REG_AW = 7;
  localparam logic [REG_AW-1:0] SEL_ID     = 7'd0;
  localparam logic [REG_AW-1:0] SEL_DEPTH  = 7'd1;
  localparam logic [REG_AW-1:0] SEL_WIDTH  = 7'd2;
  localparam logic [REG_AW-1:0] SEL_STATUS = 7'd3;
  localparam logic [REG_AW-1:0] SEL_DATA   = 7'd4;
  localparam logic [REG_AW-1:0] SEL_RDPTR  = 7'd5;
  localparam logic [REG_AW-1:0] SEL_WRPTR  = 7'd6;
  localparam logic [REG_AW-1:0] SEL_TRIG   = 7'd7;
  localparam logic [REG_AW-1:0] SEL_CTRL   = 7'd8;
  localparam logic [31:0] ID_VALUE = 32'h7C0B_0001;

  typedef struct packed {
    logic store;      // write traceWord at wrPtr, step wrPtr
    logic rdAdvance;  // step rdPtr after a data read
    logic rdLoad;     // load rdPtr from host
    logic wrLoad;     // load wrPtr from host
  } ringStrobe_t;
endpackage

// File: rtl/trb_datapath.sv
module trb_datapath
  import trb_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = 24,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ringStrobe_t      strobe,
  input  logic [WIDTH-1:0] traceWord,
  input  logic [PTR_W-1:0] loadVal,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic [WIDTH-1:0] rdWord,
  output logic             wrapPulse
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam bit POW2 = (DEPTH == (1 << PTR_W));

  logic [WIDTH-1:0] ram [DEPTH];
  logic [PTR_W-1:0] wrNext, rdNext;

  generate
    if (POW2) begin : g_natWrap
      assign wrNext = wrPtr + 1'b1;
      assign rdNext = rdPtr + 1'b1;
    end else begin : g_cmpWrap
      assign wrNext = (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      assign rdNext = (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
    end
  endgenerate

  assign wrapPulse = strobe.store && (wrPtr == LAST);
  assign rdWord    = ram[rdPtr];

  always_ff @(posedge clk) begin
    if (strobe.store) ram[wrPtr] <= traceWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.wrLoad)     wrPtr <= loadVal;
      else if (strobe.store) wrPtr <= wrNext;
      if (strobe.rdLoad)         rdPtr <= loadVal;
      else if (strobe.rdAdvance) rdPtr <= rdNext;
    end
  end
endmodule

// File: rtl/trb_control.sv
module trb_control
  import trb_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = 24,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              traceValid,
  input  logic              trigIn,
  input  logic [REG_AW-1:0] regSel,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [31:0]       regWrData,
  input  logic [PTR_W-1:0]  wrPtr,
  input  logic [PTR_W-1:0]  rdPtr,
  input  logic [WIDTH-1:0]  rdWord,
  input  logic              wrapPulse,
  output ringStrobe_t       strobe,
  output logic [31:0]       regRdData,
  output logic [3:0]        statusWord
);
  logic capEn, demuxMode, wrapped, triggered, complete;
  logic [31:0] trigCount, remaining;
  logic active, stopNow, ctrlWr;
  logic [31:0] rdMux;

  assign active  = capEn && !complete;
  assign stopNow = triggered && (remaining == '0);
  assign ctrlWr  = regWrEn && (regSel == SEL_CTRL);

  always_comb begin
    strobe.store     = active && !stopNow && traceValid;
    strobe.rdAdvance = regRdEn && (regSel == SEL_DATA);
    strobe.rdLoad    = regWrEn && (regSel == SEL_RDPTR);
    strobe.wrLoad    = regWrEn && (regSel == SEL_WRPTR);
  end

  assign statusWord = {!active, complete, triggered, wrapped};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capEn     <= 1'b0;
      demuxMode <= 1'b0;
      wrapped   <= 1'b0;
      triggered <= 1'b0;
      complete  <= 1'b0;
      remaining <= '0;
    end else if (ctrlWr) begin
      capEn     <= regWrData[0];
      demuxMode <= regWrData[1];
      if (regWrData[0]) begin
        wrapped   <= 1'b0;
        triggered <= 1'b0;
        complete  <= 1'b0;
        remaining <= '0;
      end
    end else begin
      if (wrapPulse) wrapped <= 1'b1;
      if (active && trigIn && !triggered) begin
        triggered <= 1'b1;
        remaining <= trigCount;
      end else if (strobe.store && triggered && remaining != '0) begin
        remaining <= remaining - 1'b1;
      end
      if (active && stopNow) complete <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) trigCount <= '0;
    else if (regWrEn && regSel == SEL_TRIG) trigCount <= regWrData;
  end

  always_comb begin
    unique case (regSel)
      SEL_ID:     rdMux = ID_VALUE;
      SEL_DEPTH:  rdMux = 32'(DEPTH);
      SEL_WIDTH:  rdMux = 32'(WIDTH);
      SEL_STATUS: rdMux = {28'b0, statusWord};
      SEL_DATA:   rdMux = 32'(rdWord);
      SEL_RDPTR:  rdMux = 32'(rdPtr);
      SEL_WRPTR:  rdMux = 32'(wrPtr);
      SEL_TRIG:   rdMux = trigCount;
      SEL_CTRL:   rdMux = {30'b0, demuxMode, capEn};
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) regRdData <= '0;
    else if (regRdEn) regRdData <= rdMux;
  end
endmodule

// File: rtl/trace_ring_buffer.sv
module trace_ring_buffer
  import trb_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = 24,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             traceValid,
  input  logic [WIDTH-1:0] traceWord,
  input  logic             trigIn,
  input  logic [6:0]       regSel,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  output logic [3:0]       statusWord
);
  ringStrobe_t      strobe;
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [WIDTH-1:0] rdWord;
  logic             wrapPulse;
  logic             storeStb, wrLoadStb;

  assign storeStb  = strobe.store;
  assign wrLoadStb = strobe.wrLoad;

  trb_control #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .traceValid(traceValid), .trigIn(trigIn),
    .regSel(regSel), .regWrEn(regWrEn), .regRdEn(regRdEn), .regWrData(regWrData),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .rdWord(rdWord), .wrapPulse(wrapPulse),
    .strobe(strobe), .regRdData(regRdData), .statusWord(statusWord)
  );

  trb_datapath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .traceWord(traceWord),
    .loadVal(regWrData[PTR_W-1:0]), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .rdWord(rdWord), .wrapPulse(wrapPulse)
  );
endmodule

// File: rtl/trb_checker.sv
module trb_checker #(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic             regRdEn,
  input logic [6:0]       regSel,
  input logic [31:0]      regWrData,
  input logic [3:0]       statusWord,
  input logic             storeStb,
  input logic             wrLoadStb,
  input logic [PTR_W-1:0] wrPtr,
  input logic [PTR_W-1:0] rdPtr
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  function automatic logic [PTR_W-1:0] stepOf(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : PTR_W'(p + 1'b1);
  endfunction

  logic ctrlWr;
  assign ctrlWr = regWrEn && regSel == 7'd8;

  assert_done_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[2] && !ctrlWr |=> statusWord[2]);

  assert_no_store_done_R5: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[2] |-> !storeStb);

  assert_wrap_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[0] && !ctrlWr |=> statusWord[0]);

  assert_wrptr_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    storeStb && !wrLoadStb |=> wrPtr == stepOf($past(wrPtr)));

  assert_rdptr_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn && regSel == 7'd4 && !regWrEn |=> rdPtr == stepOf($past(rdPtr)));

  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr && regWrData[0] |=> statusWord[2:0] == 3'b000);
endmodule

bind trace_ring_buffer trb_checker #(.DEPTH(DEPTH)) u_trbChk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
  .regSel(regSel), .regWrData(regWrData), .statusWord(statusWord),
  .storeStb(storeStb), .wrLoadStb(wrLoadStb), .wrPtr(wrPtr), .rdPtr(rdPtr)
);

// File: tb/trace_ring_buffer_bench.sv
`timescale 1ns/1ps
module trace_ring_buffer_bench;
  localparam int D = 16;
  localparam int W = 24;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0, tv = 1'b0, tg = 1'b0, we = 1'b0, re = 1'b0;
  logic [W-1:0] tw = '0;
  logic [6:0] sel = '0;
  logic [31:0] wd = '0;
  logic [31:0] regRdData;
  logic [3:0] statusWord;

  trace_ring_buffer #(.DEPTH(D), .WIDTH(W)) u_trace_ring_buffer (
    .clk(clk), .rstN(rstN), .traceValid(tv), .traceWord(tw), .trigIn(tg),
    .regSel(sel), .regWrEn(we), .regRdEn(re), .regWrData(wd),
    .regRdData(regRdData), .statusWord(statusWord)
  );

  // behavioural reference state
  int mem [D];
  int mWr = 0, mRd = 0, mRem = 0;
  bit [31:0] mTrig = 0, mRdData = 0;
  bit mEn = 0, mDmx = 0, mFull = 0, mTrg = 0, mDone = 0;
  int total = 0, bad = 0;
  bit finished = 0;

  function automatic bit [3:0] mStatus();
    return {(!mEn || mDone), mDone, mTrg, mFull};
  endfunction

  function automatic bit [31:0] mReg(int a);
    case (a)
      0: return 32'h7C0B_0001;
      1: return D;
      2: return W;
      3: return {28'b0, mStatus()};
      4: return mem[mRd] & ((1 << W) - 1);
      5: return mRd;
      6: return mWr;
      7: return mTrig;
      8: return {30'b0, mDmx, mEn};
      default: return 0;
    endcase
  endfunction

  task automatic modelStep();
    bit active, stop, st, ctrlW, wrapped;
    active = mEn && !mDone;
    stop = mTrg && mRem == 0;
    st = active && !stop && tv;
    ctrlW = we && sel == 8;
    wrapped = 0;
    if (re) mRdData = mReg(sel);
    if (st) begin
      mem[mWr] = tw;
      wrapped = (mWr == D - 1);
      mWr = (mWr + 1) % D;
    end
    if (ctrlW) begin
      mEn = wd[0]; mDmx = wd[1];
      if (wd[0]) begin mFull = 0; mTrg = 0; mDone = 0; mRem = 0; end
    end else begin
      if (wrapped) mFull = 1;
      if (active && tg && !mTrg) begin mTrg = 1; mRem = mTrig; end
      else if (st && mTrg && mRem != 0) mRem = mRem - 1;
      if (active && stop) mDone = 1;
    end
    if (re && sel == 4) mRd = (mRd + 1) % D;
    if (we && sel == 5) mRd = wd % D;
    if (we && sel == 6) mWr = wd % D;
    if (we && sel == 7) mTrig = wd;
  endtask

  task automatic chk(string tag, bit [31:0] act, bit [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(string tag);
    modelStep();
    @(posedge clk);
    @(negedge clk);
    chk({tag, "/R11 status"}, {28'b0, statusWord}, {28'b0, mStatus()});
    chk({tag, "/R10 rddata"}, regRdData, mRdData);
  endtask

  task automatic regWrite(int a, bit [31:0] v, string tag);
    sel = 7'(a); wd = v; we = 1;
    tick(tag);
    we = 0;
  endtask

  task automatic regRead(int a, string tag);
    sel = 7'(a); re = 1;
    tick(tag);
    re = 0;
  endtask

  // n cycles of stream; valid when bit (i % 3) not hit by gap; trigger at cycle trigAt
  task automatic stream(int n, int trigAt, bit gaps, int seed, string tag);
    for (int i = 0; i < n; i++) begin
      tv = gaps ? (i % 3 != 2) : 1'b1;
      tw = W'(seed * 4099 + i * 131 + 7);
      tg = (i == trigAt);
      tick(tag);
    end
    tv = 0; tg = 0;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < D; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 reset status", {28'b0, statusWord}, 32'h8);
    chk("R1 reset rddata", regRdData, 0);
    regRead(5, "R1 rdptr");
    regRead(6, "R1 wrptr");
    regRead(8, "R1 ctrl");
    // fixed registers, writes ignored
    regRead(0, "R2 id");
    regRead(1, "R2 depth");
    regRead(2, "R2 width");
    regWrite(1, 32'h55, "R2 depth write");
    regWrite(0, 32'h1234, "R2 id write");
    regRead(1, "R2 depth after write");
    regRead(0, "R2 id after write");
    // no store while disabled
    stream(4, 1, 0, 1, "R3 disabled");
    regRead(6, "R3 wrptr idle");
    // short capture: trigger early, count 3
    regWrite(7, 3, "R7 trig");
    regRead(7, "R7 trig readback");
    regWrite(6, 0, "R7 wrptr");
    regWrite(8, 3, "R8 enable demux");
    regRead(8, "R8 ctrl readback");
    regRead(3, "R9 running");
    stream(10, 2, 0, 2, "R5 countdown");
    regRead(3, "R5 status");
    regRead(6, "R5 wrptr");
    stream(3, 0, 0, 9, "R5 retrigger");
    regRead(6, "R5 no store after done");
    regWrite(5, 0, "R7 rdptr");
    for (int i = 0; i < 7; i++) regRead(4, "R6 drain");
    regRead(5, "R6 rdptr");
    // wrap capture with gaps, late trigger
    regWrite(7, 5, "R7 trig");
    regWrite(6, 0, "R7 wrptr");
    regWrite(8, 1, "R8 reenable");
    stream(30, 26, 1, 3, "R4 wrap");
    stream(12, 99, 1, 4, "R5 tail");
    regRead(3, "R4 status");
    regRead(6, "R4 wrptr");
    regWrite(5, mWr, "R7 rdptr oldest");
    for (int i = 0; i < D + 2; i++) regRead(4, "R6 ring drain");
    // zero count: stop right after trigger
    regWrite(7, 0, "R7 trig zero");
    regWrite(8, 1, "R8 clear flags");
    stream(6, 2, 0, 5, "R5 zero count");
    regRead(6, "R5 zero wrptr");
    // stop via control 0 keeps flags
    regWrite(8, 1, "R8 restart");
    stream(20, 99, 0, 6, "R4 wrap again");
    regWrite(8, 0, "R8 stop");
    regRead(3, "R8 flags kept");
    stream(4, 1, 0, 7, "R9 stopped");
    regRead(6, "R3 no store stopped");
    regRead(8, "R8 ctrl off");
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule